// File: doc/BRIEF.md
# Little-Endian Load/Store Byte-Lane Unit

This unit sits between a 32-bit processor datapath and a memory that is one word wide. Each load or store request has a byte or word size and a byte address. The unit turns it into an aligned word access. Memory holds words little-endian: the lowest byte address of an aligned word holds its least significant byte. For a store, the unit produces the word address, one write strobe per byte lane and the lane-placed write data.

For a load, the memory returns the aligned word one clock after the request. In that cycle the unit formats the word into register form, using the offset and size it captured with the request. Word loads are also allowed at offset 2 of a word. In that case the unit returns the aligned word with its two 16-bit halves exchanged; it does not split the access or raise a fault. A word access that the rules do not allow is reported on a one-cycle misalignment flag, and it neither writes memory nor produces a load result.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr_o` equals `req_addr_i` with bits 1:0 forced to zero, in the same cycle as the request.
- R2: A word store to an address with bits 1:0 = 00 drives `mem_be_o` = 4'b1111 and `mem_wdata_o` = `req_wdata_i`.
- R3: A byte store asserts exactly one strobe, bit `req_addr_i[1:0]` of `mem_be_o` (bit 0 is the lowest byte address), and places `req_wdata_i[7:0]` on all four write-data lanes. The other three bytes of the word keep their contents.
- R4: A word store whose address bits 1:0 are not 00 raises `misalign_o` in the request cycle and drives `mem_be_o` to zero, so memory is unchanged.
- R5: A word load at offset 00 gives `load_valid_o` = 1 one cycle after the request, with `load_data_o` equal to the aligned memory word. Example: bytes 01,02,03,04 at offsets 0..3 give 0x04030201.
- R6: A word load at offset 10 returns the aligned word with its upper and lower 16-bit halves exchanged. The same example word gives 0x02010403.
- R7: A byte load returns the addressed byte in bits 7:0 and zero in bits 31:8. Example: offset 3 of the example word gives 0x00000004.
- R8: A word load with address bit 0 set raises `misalign_o` in the request cycle, and `load_valid_o` stays low in the following cycle.
- R9: When `req_valid_i` is low, `mem_be_o` is zero and `misalign_o` is low. `load_valid_o` is high only in the cycle after an accepted load.
- R10: After reset, `load_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_byte_i | input | 1 | 1 = byte access, 0 = word access |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data in register format |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Byte write strobes, bit n = byte offset n |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_rdata_i | input | 32 | Memory read word, one cycle after address |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Formatted load result |
| misalign_o | output | 1 | Request rejected as misaligned |

## Verification
The hardest case to reach from the ports is a byte store whose correct effect depends on lanes it must not touch. A wrong strobe or a wrong lane shows up only when a later load reads the neighbouring bytes of that same word. The stimulus therefore confines random addresses to a 16-word window, so stores and loads keep hitting the same words at every offset. A shadow memory kept by the bench supplies every expected load value. Directed cases cover the offset-2 half swap and every misaligned word offset for both loads and stores.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_LD_WORD = 3'd1,
    OP_LD_BYTE = 3'd2,
    OP_ST_WORD = 3'd3,
    OP_ST_BYTE = 3'd4
  } lsu_op_e;
endpackage

// File: rtl/lsu_req_decode.sv
module lsu_req_decode
  import lsu_lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             valid_i,
  input  logic             store_i,
  input  logic             byte_i,
  input  logic [OFF_W-1:0] off_i,
  output lsu_op_e          op_o,
  output logic             misalign_o
);
  logic st_bad, ld_bad;

  // word store needs full alignment; word load only needs even address
  assign st_bad = valid_i && store_i && !byte_i && (off_i != '0);
  assign ld_bad = valid_i && !store_i && !byte_i && off_i[0];
  assign misalign_o = st_bad || ld_bad;

  always_comb begin
    op_o = OP_NONE;
    if (valid_i && !misalign_o) begin
      unique case ({store_i, byte_i})
        2'b00:   op_o = OP_LD_WORD;
        2'b01:   op_o = OP_LD_BYTE;
        2'b10:   op_o = OP_ST_WORD;
        default: op_o = OP_ST_BYTE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  lsu_op_e           op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_o[l] = (op_i == OP_ST_WORD) ||
                     ((op_i == OP_ST_BYTE) && (off_i == OFF_W'(l)));
    assign wdata_o[l*8 +: 8] = (op_i == OP_ST_BYTE) ? wdata_i[7:0]
                                                    : wdata_i[l*8 +: 8];
  end
endmodule

// File: rtl/lsu_load_format.sv
module lsu_load_format #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              byte_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rot;
  logic [7:0]        sel;

  // rotate right by whole lanes; offset 2 on 32 bits swaps halves
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rot[l*8 +: 8] = rdata_i[((l + int'(off_i)) % LANES)*8 +: 8];
    end
  end

  assign sel    = rot[7:0];
  assign data_o = byte_i ? {{(DATA_W-8){1'b0}}, sel} : rot;
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic              req_byte_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              misalign_o
);
  lsu_op_e          op;
  logic [OFF_W-1:0] off;
  logic             ld_vld_q, ld_byte_q;
  logic [OFF_W-1:0] ld_off_q;

  assign off        = req_addr_i[OFF_W-1:0];
  assign mem_addr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsu_req_decode #(.OFF_W(OFF_W)) u_dec (
    .valid_i   (req_valid_i),
    .store_i   (req_store_i),
    .byte_i    (req_byte_i),
    .off_i     (off),
    .op_o      (op),
    .misalign_o(misalign_o)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
    .op_i   (op),
    .off_i  (off),
    .wdata_i(req_wdata_i),
    .be_o   (mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_vld_q  <= 1'b0;
      ld_byte_q <= 1'b0;
      ld_off_q  <= '0;
    end else begin
      ld_vld_q <= (op == OP_LD_WORD) || (op == OP_LD_BYTE);
      if (req_valid_i && !req_store_i) begin
        ld_byte_q <= req_byte_i;
        ld_off_q  <= off;
      end
    end
  end

  lsu_load_format #(.DATA_W(DATA_W)) u_ld (
    .rdata_i(mem_rdata_i),
    .byte_i (ld_byte_q),
    .off_i  (ld_off_q),
    .data_o (load_data_o)
  );

  assign load_valid_o = ld_vld_q;
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic              req_byte_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LANES-1:0]  mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              load_valid_o,
  input logic [DATA_W-1:0] load_data_o,
  input logic              misalign_o
);
  // R1
  addr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_addr_o[1:0] == 2'b00 && mem_addr_o[ADDR_W-1:2] == req_addr_i[ADDR_W-1:2]);
  // R2
  word_store_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && !req_byte_i && req_addr_i[1:0] == 2'b00)
      |-> (mem_be_o == '1 && mem_wdata_o == req_wdata_i));
  // R3
  byte_store_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && req_byte_i) |-> ($countones(mem_be_o) == 1));
  // R4
  misalign_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == '0));
  // R8
  load_valid_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> $past(req_valid_i && !req_store_i && !misalign_o));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (mem_be_o == '0 && !misalign_o));
endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_lsu_lane_unit.sv
module sim_lsu_lane_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_byte_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [31:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  mem_be_o;
  logic        load_valid_o, misalign_o;

  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk_i = ~clk_i;

  lsu_lane_unit u0 (.*);

  always @(posedge clk_i) begin
    mem_rdata_i <= mem[mem_addr_o[5:2]];
    for (int l = 0; l < 4; l++)
      if (mem_be_o[l]) mem[mem_addr_o[5:2]][l*8 +: 8] <= mem_wdata_o[l*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(input logic [31:0] w, input logic [1:0] off, input bit is_b);
    logic [7:0] b;
    b = (off == 0) ? w[7:0] : (off == 1) ? w[15:8] : (off == 2) ? w[23:16] : w[31:24];
    if (is_b) return {24'h0, b};
    return (off == 2) ? {w[15:0], w[31:16]} : w;
  endfunction

  task automatic op(input bit st, input bit by, input logic [31:0] a, input logic [31:0] d);
    bit bad;
    logic [31:0] exp_w;
    logic [3:0] exp_be;
    @(negedge clk_i);
    req_valid_i = 1; req_store_i = st; req_byte_i = by; req_addr_i = a; req_wdata_i = d;
    bad = !by && (st ? (a[1:0] != 0) : a[0]);
    #1;
    chk(mem_addr_o == {a[31:2], 2'b00}, "R1", mem_addr_o, {a[31:2], 2'b00});
    chk(misalign_o == bad, bad ? (st ? "R4" : "R8") : "R9", 32'(misalign_o), 32'(bad));
    exp_be = 4'h0;
    if (st && !bad) exp_be = by ? (4'h1 << a[1:0]) : 4'hF;
    chk(mem_be_o == exp_be, st ? (by ? "R3" : (bad ? "R4" : "R2")) : "R9", 32'(mem_be_o), 32'(exp_be));
    if (st && !bad && !by) chk(mem_wdata_o == d, "R2", mem_wdata_o, d);
    if (st && by) chk(mem_wdata_o == {4{d[7:0]}}, "R3", mem_wdata_o, {4{d[7:0]}});
    exp_w = shadow[a[5:2]];
    if (st && !bad) begin
      if (by) shadow[a[5:2]][a[1:0]*8 +: 8] = d[7:0];
      else shadow[a[5:2]] = d;
    end
    @(negedge clk_i);
    req_valid_i = 0;
    #1;
    chk(load_valid_o == (!st && !bad), bad ? "R8" : "R9", 32'(load_valid_o), 32'(!st && !bad));
    if (!st && !bad)
      chk(load_data_o == fmt(exp_w, a[1:0], by), by ? "R7" : (a[1] ? "R6" : "R5"),
          load_data_o, fmt(exp_w, a[1:0], by));
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog act=%h exp=%h", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    for (int i = 0; i < 16; i++) begin
      shadow[i] = {8'(4*i+4), 8'(4*i+3), 8'(4*i+2), 8'(4*i+1)};
      mem[i] = shadow[i];
    end
    #1;
    chk(load_valid_o == 1'b0, "R10", 32'(load_valid_o), 32'h0);
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(load_valid_o == 1'b0, "R10", 32'(load_valid_o), 32'h0);
    // directed corners
    op(0, 0, 32'h4000_0000, 0);              // R5 0x04030201
    chk(load_data_o == 32'h0403_0201, "R5", load_data_o, 32'h0403_0201);
    op(0, 0, 32'h4000_0002, 0);              // R6 half swap
    chk(load_data_o == 32'h0201_0403, "R6", load_data_o, 32'h0201_0403);
    op(0, 1, 32'h4000_0003, 0);              // R7
    chk(load_data_o == 32'h0000_0004, "R7", load_data_o, 32'h0000_0004);
    op(0, 0, 32'h4000_0001, 0);              // R8
    op(0, 0, 32'h4000_0003, 0);              // R8
    for (int o = 1; o < 4; o++) op(1, 0, 32'h4000_0010 | o, 32'hDEAD_BEEF); // R4
    op(0, 0, 32'h4000_0010, 0);              // R4 word untouched
    op(1, 1, 32'h4000_0021, 32'h1234_56A5);  // R3 lane 1 only
    op(0, 0, 32'h4000_0020, 0);              // R3 neighbours kept
    op(1, 0, 32'h4000_0030, 32'hCAFE_F00D);  // R2
    op(0, 0, 32'h4000_0032, 0);              // R6 after store
    // random mix
    for (int n = 0; n < 400; n++)
      op(1'($urandom), 1'($urandom), {$urandom} & 32'hFFFF_FF3F, $urandom);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule